// File: doc/BRIEF.md
# Debug Halt Watch Unit

This block sits beside a processor core and watches its memory bus. It holds two independent comparator units. Each unit compares the bus address, the bus data and a group of bus control bits against programmed values, and any bit can be left out of the comparison through a mask. A unit in watch mode fires on a matching data access. A unit in break mode tags a matching instruction fetch and fires only once that instruction has moved down the core's pipeline into the execute stage. A flush of the pipeline drops the tag.

When either unit fires, or when the external debug request input is raised, the block asserts `halt`. It records which sources caused the entry and holds that record until a restart command arrives. While halted, it overrides the cycle type that goes out to the memory system so that only internal cycles are shown. The registers are loaded through a simple write-only port, which stands in for the test access port of a debug chain.

Top module: `dbg_halt_watch`

## Requirements
- R1: After reset `halt` is 0 and `halt_cause` is 0. Both units are disabled, so a bus access that equals the reset register values does not halt.
- R2: A bus cycle with `bus_valid`=1 and `bus_fetch`=0 halts the block if it matches an enabled unit in watch mode. `halt` is 1 at the next clock edge. `halt_cause` bit 0 marks unit 0 and bit 1 marks unit 1.
- R3: A match needs the address, the data and the control bits to agree at the same time. A mask bit set to 1 removes that bit position from the comparison.
- R4: A watch-mode unit ignores fetch cycles. A break-mode unit ignores data accesses.
- R5: In break mode, a matching fetch is recorded only in a cycle with `pipe_adv`=1. It moves one stage per further `pipe_adv`. After EXEC_STAGES advances in total, counting the fetch, the instruction is in execute, and `halt` rises at the next edge. It does not rise at the fetch.
- R6: A cycle with `pipe_flush`=1 discards every pending break tag, so the flushed instructions never halt the block.
- R7: A unit whose enable bit is 0 never causes a halt, even when its comparison matches.
- R8: `dbg_req`=1 in a running cycle halts the block at the next edge and sets `halt_cause` bit 2. This holds whatever the state of the units.
- R9: `halt_cause` records every source that fires in the entry cycle. It is 0 while running and stays unchanged while halted, even if further triggers arrive.
- R10: `halt` stays 1 until a restart command. A restart command is a write to register 16 with data bit 0 set. At the next edge the restart clears `halt`, `halt_cause` and all pending break tags.
- R11: While running, `mem_cycle` equals `core_cycle`. While halted, `mem_cycle` is 2'b00, the internal-cycle code. The other codes are 01 sequential, 10 non-sequential and 11 coprocessor.
- R12: Each unit n has its registers at word addresses 8n+k. The offsets k are: 0 address value, 1 address mask, 2 data value, 3 data mask, 4 control value, 5 control mask, and 6 configuration. In the configuration register, bit 0 is enable and bit 1 selects watch mode (1) or break mode (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word address |
| cfg_wdata | input | DATA_W | Register write data |
| bus_valid | input | 1 | A transfer is on the bus this cycle |
| bus_fetch | input | 1 | The transfer is an instruction fetch (1) or a data access (0) |
| bus_addr | input | ADDR_W | Bus address |
| bus_data | input | DATA_W | Bus data (opcode on fetches) |
| bus_ctrl | input | CTRL_W | Bus control bits compared by the units |
| pipe_adv | input | 1 | Core pipeline advances one stage |
| pipe_flush | input | 1 | Core pipeline discards its contents |
| dbg_req | input | 1 | External debug request |
| core_cycle | input | 2 | Cycle type from the core |
| halt | output | 1 | Core is held in debug state |
| halt_cause | output | 3 | Entry sources: bit 0 unit 0, bit 1 unit 1, bit 2 external |
| mem_cycle | output | 2 | Cycle type shown to the memory system |

## Verification
The bench builds the block with ADDR_W=16, DATA_W=16, CTRL_W=3 and EXEC_STAGES=3. With narrow fields, a single differing bit in each field can be written out directly, masked and unmasked, in the vector table. Three pipeline stages leave two separate advances between a tagged fetch and its execute stage. That gap lets the bench sample the early-halt window, a flush and a restart while a tag is still in flight.

// File: rtl/wpt_pkg.sv
// Shared constants for the debug halt watch unit.
// Assumes a fixed pair of comparator units, each with an 8-word register window.
package wpt_pkg;
    localparam int NUM_UNITS   = 2;
    localparam int REG_AW      = 5;
    localparam int UNIT_STRIDE = 8;
    localparam int OFS_W       = $clog2(UNIT_STRIDE);

    localparam logic [OFS_W-1:0] OFS_AVAL = 3'd0;
    localparam logic [OFS_W-1:0] OFS_AMSK = 3'd1;
    localparam logic [OFS_W-1:0] OFS_DVAL = 3'd2;
    localparam logic [OFS_W-1:0] OFS_DMSK = 3'd3;
    localparam logic [OFS_W-1:0] OFS_CVAL = 3'd4;
    localparam logic [OFS_W-1:0] OFS_CMSK = 3'd5;
    localparam logic [OFS_W-1:0] OFS_CFG  = 3'd6;

    localparam logic [REG_AW-1:0] REG_RESTART = 5'd16;

    localparam int CFG_EN_BIT    = 0;
    localparam int CFG_WATCH_BIT = 1;

    typedef enum logic [1:0] {
        CYC_INTERNAL = 2'b00,
        CYC_SEQ      = 2'b01,
        CYC_NONSEQ   = 2'b10,
        CYC_COPROC   = 2'b11
    } cyc_t;
endpackage

// File: rtl/wpt_cmp.sv
// One comparator unit: holds its value, mask and configuration registers
// and compares them against the bus. It reports a fetch match (break mode)
// or a data match (watch mode). Assumes ADDR_W and CTRL_W <= DATA_W.
module wpt_cmp
    import wpt_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int CTRL_W   = 4,
    parameter int UNIT_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bus_valid,
    input  logic              bus_fetch,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [CTRL_W-1:0] bus_ctrl,
    output logic              fetch_hit,
    output logic              data_hit
);
    localparam logic [REG_AW-1:0] BASE = REG_AW'(UNIT_IDX * UNIT_STRIDE);

    logic [ADDR_W-1:0] a_val, a_msk;
    logic [DATA_W-1:0] d_val, d_msk;
    logic [CTRL_W-1:0] c_val, c_msk;
    logic              en, watch;
    logic              sel, all_ok;
    logic [OFS_W-1:0]  ofs;
    logic              unused_wdata;

    assign unused_wdata = ^wr_data;
    assign sel = wr_en && (wr_addr[REG_AW-1:OFS_W] == BASE[REG_AW-1:OFS_W]);
    assign ofs = wr_addr[OFS_W-1:0];

    // Register file of this unit, loaded from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_val <= '0; a_msk <= '0;
            d_val <= '0; d_msk <= '0;
            c_val <= '0; c_msk <= '0;
            en    <= 1'b0; watch <= 1'b0;
        end else if (sel) begin
            case (ofs)
                OFS_AVAL: a_val <= wr_data[ADDR_W-1:0];
                OFS_AMSK: a_msk <= wr_data[ADDR_W-1:0];
                OFS_DVAL: d_val <= wr_data;
                OFS_DMSK: d_msk <= wr_data;
                OFS_CVAL: c_val <= wr_data[CTRL_W-1:0];
                OFS_CMSK: c_msk <= wr_data[CTRL_W-1:0];
                OFS_CFG: begin
                    en    <= wr_data[CFG_EN_BIT];
                    watch <= wr_data[CFG_WATCH_BIT];
                end
                default: ;
            endcase
        end
    end

    // Masked three-field comparison against the current bus cycle.
    always_comb begin
        all_ok = (((bus_addr ^ a_val) & ~a_msk) == '0)
              && (((bus_data ^ d_val) & ~d_msk) == '0)
              && (((bus_ctrl ^ c_val) & ~c_msk) == '0);
        fetch_hit = en && !watch && bus_valid &&  bus_fetch && all_ok;
        data_hit  = en &&  watch && bus_valid && !bus_fetch && all_ok;
    end
endmodule

// File: rtl/wpt_exec_pipe.sv
// Carries break-mode tags alongside the core pipeline from fetch to execute.
// Assumes one tag bit per unit per stage, shifting only on pipeline advance.
module wpt_exec_pipe #(
    parameter int UNITS  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             flush,
    input  logic             clear,
    input  logic [UNITS-1:0] fetch_hit,
    output logic [UNITS-1:0] exec_hit
);
    logic [UNITS-1:0] stg [STAGES];

    // Shift tags one stage per advance; flush or restart empties them.
    always_ff @(posedge clk) begin
        if (!rst_n || flush || clear) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else if (adv) begin
            stg[0] <= fetch_hit;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign exec_hit = stg[STAGES-1];
endmodule

// File: rtl/wpt_halt_ctrl.sv
// Halt state, entry cause record and memory cycle-type override.
// Assumes triggers are only looked at while running; restart takes priority.
module wpt_halt_ctrl
    import wpt_pkg::*;
#(
    parameter int SRC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [SRC_W-1:0] trig,
    input  logic [1:0]       core_cycle,
    output logic             halted,
    output logic [SRC_W-1:0] cause,
    output logic [1:0]       mem_cycle
);
    // Enter halt on any trigger, record all sources, leave on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            halted <= 1'b0;
            cause  <= '0;
        end else if (!halted && (|trig)) begin
            halted <= 1'b1;
            cause  <= trig;
        end
    end

    // Show only internal cycles to memory while halted.
    assign mem_cycle = halted ? CYC_INTERNAL : core_cycle;
endmodule

// File: rtl/dbg_halt_watch.sv
// Top of the debug halt watch unit: two comparator units, the break tag
// pipeline and the halt controller. Assumes the core drives pipe_adv and
// pipe_flush in step with its own fetch/decode/execute pipeline.
module dbg_halt_watch
    import wpt_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int CTRL_W      = 4,
    parameter int EXEC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [4:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              bus_valid,
    input  logic              bus_fetch,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [CTRL_W-1:0] bus_ctrl,
    input  logic              pipe_adv,
    input  logic              pipe_flush,
    input  logic              dbg_req,
    input  logic [1:0]        core_cycle,
    output logic              halt,
    output logic [2:0]        halt_cause,
    output logic [1:0]        mem_cycle
);
    localparam int SRC_W = NUM_UNITS + 1;

    logic [NUM_UNITS-1:0] fetch_hit, data_hit, exec_hit;
    logic [SRC_W-1:0]     trig;
    logic                 restart;

    // Decode the restart command from the register port.
    assign restart = cfg_wr_en && (cfg_addr == REG_RESTART) && cfg_wdata[0];

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        wpt_cmp #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W), .UNIT_IDX(u)
        ) u_cmp (
            .clk(clk), .rst_n(rst_n),
            .wr_en(cfg_wr_en), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
            .bus_valid(bus_valid), .bus_fetch(bus_fetch),
            .bus_addr(bus_addr), .bus_data(bus_data), .bus_ctrl(bus_ctrl),
            .fetch_hit(fetch_hit[u]), .data_hit(data_hit[u])
        );
    end

    wpt_exec_pipe #(.UNITS(NUM_UNITS), .STAGES(EXEC_STAGES)) u_pipe (
        .clk(clk), .rst_n(rst_n), .adv(pipe_adv), .flush(pipe_flush),
        .clear(restart), .fetch_hit(fetch_hit), .exec_hit(exec_hit)
    );

    // Collect halt sources: external request above the two units.
    assign trig = {dbg_req, data_hit | exec_hit};

    wpt_halt_ctrl #(.SRC_W(SRC_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .restart(restart), .trig(trig),
        .core_cycle(core_cycle), .halted(halt), .cause(halt_cause),
        .mem_cycle(mem_cycle)
    );
endmodule

// File: rtl/dbg_halt_watch_chk.sv
// Port-level checks of halt entry, hold, cause record and cycle override.
module dbg_halt_watch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr_en,
    input logic [4:0] cfg_addr,
    input logic       cfg_wdata_lsb,
    input logic       dbg_req,
    input logic [1:0] core_cycle,
    input logic       halt,
    input logic [2:0] halt_cause,
    input logic [1:0] mem_cycle
);
    logic rst_cmd;
    assign rst_cmd = cfg_wr_en && (cfg_addr == 5'd16) && cfg_wdata_lsb;

    p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halt && !rst_cmd |=> halt);
    p_restart_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cmd |=> !halt && halt_cause == 3'b000);
    p_cause_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halt && !rst_cmd |=> $stable(halt_cause));
    p_cause_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !halt |-> halt_cause == 3'b000);
    p_cause_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> halt_cause != 3'b000);
    p_ext_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !halt && dbg_req && !rst_cmd |=> halt && halt_cause[2]);
    p_internal_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> mem_cycle == 2'b00);
    p_pass_through_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !halt |-> mem_cycle == core_cycle);
endmodule

bind dbg_halt_watch dbg_halt_watch_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata_lsb(cfg_wdata[0]), .dbg_req(dbg_req), .core_cycle(core_cycle),
    .halt(halt), .halt_cause(halt_cause), .mem_cycle(mem_cycle)
);

// File: tb/dbg_halt_watch_test.sv
module dbg_halt_watch_test;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 3;
    localparam int ST = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [4:0]    cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic          bus_valid = 1'b0, bus_fetch = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_data = '0;
    logic [CW-1:0] bus_ctrl = '0;
    logic          pipe_adv = 1'b0, pipe_flush = 1'b0, dbg_req = 1'b0;
    logic [1:0]    core_cycle = 2'b01;
    logic          halt;
    logic [2:0]    halt_cause;
    logic [1:0]    mem_cycle;

    int n_chk = 0;
    int n_fail = 0;

    always #10ns clk = ~clk;

    dbg_halt_watch #(.ADDR_W(AW), .DATA_W(DW), .CTRL_W(CW), .EXEC_STAGES(ST)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_fetch(bus_fetch),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_ctrl(bus_ctrl),
        .pipe_adv(pipe_adv), .pipe_flush(pipe_flush), .dbg_req(dbg_req),
        .core_cycle(core_cycle), .halt(halt), .halt_cause(halt_cause),
        .mem_cycle(mem_cycle)
    );

    typedef struct packed {
        logic [15:0] aval, amsk, dval, dmsk;
        logic [2:0]  cval, cmsk;
        logic [15:0] ba, bd;
        logic [2:0]  bc;
        logic        fetch;
        logic        hit;
    } vec_t;

    // Unit 0 in watch mode: masked and unmasked single-bit differences.
    localparam vec_t VECS [8] = '{
        '{16'h1234, 16'h0000, 16'hBEEF, 16'h0000, 3'b101, 3'b000, 16'h1234, 16'hBEEF, 3'b101, 1'b0, 1'b1},
        '{16'h1234, 16'h0000, 16'hBEEF, 16'h0000, 3'b101, 3'b000, 16'h1235, 16'hBEEF, 3'b101, 1'b0, 1'b0},
        '{16'h1234, 16'h0001, 16'hBEEF, 16'h0000, 3'b101, 3'b000, 16'h1235, 16'hBEEF, 3'b101, 1'b0, 1'b1},
        '{16'h1234, 16'h0000, 16'hBEEF, 16'h0000, 3'b101, 3'b000, 16'h1234, 16'hBEEE, 3'b101, 1'b0, 1'b0},
        '{16'h1234, 16'h0000, 16'hBEEF, 16'h00FF, 3'b101, 3'b000, 16'h1234, 16'hBE00, 3'b101, 1'b0, 1'b1},
        '{16'h1234, 16'h0000, 16'hBEEF, 16'h0000, 3'b101, 3'b000, 16'h1234, 16'hBEEF, 3'b100, 1'b0, 1'b0},
        '{16'h1234, 16'h0000, 16'hBEEF, 16'h0000, 3'b101, 3'b001, 16'h1234, 16'hBEEF, 3'b100, 1'b0, 1'b1},
        '{16'h1234, 16'h0000, 16'hBEEF, 16'h0000, 3'b101, 3'b000, 16'h1234, 16'hBEEF, 3'b101, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic restart_cmd();
        wr(5'd16, 16'h0001);
    endtask

    task automatic prog(input int u, input logic [15:0] av, am, dv, dm,
                        input logic [2:0] cv, cm, input logic [15:0] cfg);
        logic [4:0] b;
        b = 5'(u * 8);
        wr(b + 5'd0, av); wr(b + 5'd1, am);
        wr(b + 5'd2, dv); wr(b + 5'd3, dm);
        wr(b + 5'd4, 16'(cv)); wr(b + 5'd5, 16'(cm));
        wr(b + 5'd6, cfg);
    endtask

    task automatic bus_cyc(input logic [15:0] a, d, input logic [2:0] c,
                           input logic f, input logic adv);
        bus_valid = 1'b1; bus_fetch = f; bus_addr = a; bus_data = d;
        bus_ctrl = c; pipe_adv = adv;
        @(negedge clk);
        bus_valid = 1'b0; pipe_adv = 1'b0;
    endtask

    task automatic adv_cyc(input int n);
        for (int i = 0; i < n; i++) begin
            pipe_adv = 1'b1;
            @(negedge clk);
            pipe_adv = 1'b0;
        end
    endtask

    initial begin
        #(20ns * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 halt after reset", 32'(halt), 32'd0);
        chk("R1 cause after reset", 32'(halt_cause), 32'd0);
        chk("R11 pass-through running", 32'(mem_cycle), 32'd1);
        // R1/R7: reset-value registers would match an all-zero access if enabled
        bus_cyc(16'h0000, 16'h0000, 3'b000, 1'b0, 1'b0);
        chk("R1 disabled at reset", 32'(halt), 32'd0);

        // R2 R3 R4 R12: vector table on unit 0 (cfg 3 = enable + watch)
        for (int i = 0; i < 8; i++) begin
            prog(0, VECS[i].aval, VECS[i].amsk, VECS[i].dval, VECS[i].dmsk,
                 VECS[i].cval, VECS[i].cmsk, 16'h0003);
            bus_cyc(VECS[i].ba, VECS[i].bd, VECS[i].bc, VECS[i].fetch, 1'b0);
            chk($sformatf("R3 vector %0d halt", i), 32'(halt), 32'(VECS[i].hit));
            chk($sformatf("R2 vector %0d cause", i), 32'(halt_cause),
                VECS[i].hit ? 32'd1 : 32'd0);
            restart_cmd();
        end
        wr(5'd6, 16'h0000);

        // R7: unit 1 matching but disabled (cfg 2 = watch only)
        prog(1, 16'h0040, 16'h0000, 16'h5A5A, 16'h0000, 3'b010, 3'b000, 16'h0002);
        bus_cyc(16'h0040, 16'h5A5A, 3'b010, 1'b0, 1'b0);
        chk("R7 disabled unit", 32'(halt), 32'd0);

        // R2: unit 1 enabled
        wr(5'd14, 16'h0003);
        bus_cyc(16'h0040, 16'h5A5A, 3'b010, 1'b0, 1'b0);
        chk("R2 unit1 halt", 32'(halt), 32'd1);
        chk("R2 unit1 cause", 32'(halt_cause), 32'd2);
        core_cycle = 2'b10;
        @(negedge clk);
        chk("R11 internal while halted", 32'(mem_cycle), 32'd0);
        repeat (5) @(negedge clk);
        chk("R10 halt held", 32'(halt), 32'd1);
        // R9: later request does not change the record
        dbg_req = 1'b1; @(negedge clk); dbg_req = 1'b0;
        chk("R9 cause frozen", 32'(halt_cause), 32'd2);
        restart_cmd();
        chk("R10 restart clears halt", 32'(halt), 32'd0);
        chk("R10 restart clears cause", 32'(halt_cause), 32'd0);
        chk("R11 pass-through after restart", 32'(mem_cycle), 32'd2);
        core_cycle = 2'b01;

        // R8: external request with unit 1 disabled
        wr(5'd14, 16'h0000);
        dbg_req = 1'b1; @(negedge clk); dbg_req = 1'b0;
        chk("R8 external halt", 32'(halt), 32'd1);
        chk("R8 external cause", 32'(halt_cause), 32'd4);
        restart_cmd();

        // R9: three sources in one cycle
        prog(0, 16'h0040, 16'h0000, 16'h5A5A, 16'h0000, 3'b010, 3'b000, 16'h0003);
        wr(5'd14, 16'h0003);
        dbg_req = 1'b1;
        bus_cyc(16'h0040, 16'h5A5A, 3'b010, 1'b0, 1'b0);
        dbg_req = 1'b0;
        chk("R9 all sources", 32'(halt_cause), 32'd7);
        restart_cmd();

        // Break mode on unit 0 (cfg 1 = enable, break)
        wr(5'd14, 16'h0000);
        prog(0, 16'h0100, 16'h0000, 16'hE3A0, 16'h0000, 3'b001, 3'b000, 16'h0001);
        // R4: matching data access ignored by break unit
        bus_cyc(16'h0100, 16'hE3A0, 3'b001, 1'b0, 1'b1);
        adv_cyc(3); @(negedge clk);
        chk("R4 break ignores data", 32'(halt), 32'd0);
        // R5: fetch without advance is not recorded
        bus_cyc(16'h0100, 16'hE3A0, 3'b001, 1'b1, 1'b0);
        adv_cyc(3); @(negedge clk);
        chk("R5 stalled fetch", 32'(halt), 32'd0);
        // R5: tag reaches execute after three advances
        bus_cyc(16'h0100, 16'hE3A0, 3'b001, 1'b1, 1'b1);
        chk("R5 no halt at fetch", 32'(halt), 32'd0);
        adv_cyc(1);
        chk("R5 no halt in decode", 32'(halt), 32'd0);
        adv_cyc(1);
        chk("R5 no halt entering execute", 32'(halt), 32'd0);
        @(negedge clk);
        chk("R5 halt at execute", 32'(halt), 32'd1);
        chk("R5 cause unit0", 32'(halt_cause), 32'd1);
        restart_cmd();
        // R6: flush drops pending tag
        bus_cyc(16'h0100, 16'hE3A0, 3'b001, 1'b1, 1'b1);
        adv_cyc(1);
        pipe_flush = 1'b1; @(negedge clk); pipe_flush = 1'b0;
        adv_cyc(3); @(negedge clk);
        chk("R6 flush cancels", 32'(halt), 32'd0);
        // R10: restart drops pending tag
        bus_cyc(16'h0100, 16'hE3A0, 3'b001, 1'b1, 1'b1);
        adv_cyc(1);
        restart_cmd();
        adv_cyc(3); @(negedge clk);
        chk("R10 restart clears tags", 32'(halt), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule